// File: doc/BRIEF.md
# Frame-Synchronized Serial Port Engine

This block moves 16-bit words between two small on-chip queues and a pair of single-bit serial lines. The bit clock is the block clock. An external frame pulse, `fsync`, marks the start of each word. On every frame start the transmitter loads the oldest queued word and shifts it out most significant bit first. On the same frame start the receiver begins to assemble one word from `sdi` and appends it to the receive queue.

Control writes arrive as a single strobe that carries both enable bits and two reset bits. A write changes only the pending value of each enable. The pending value becomes active at the next rising edge of `fsync`, so a word already on the line is never cut. The two reset bits act at once and need no clearing. Each direction reports its own queue conditions. Each direction also raises a transfer request when its queue occupancy crosses a programmable threshold, so an external mover can refill or drain the queue.

Top module: `ssp_frame_port`

## Requirements
- R1: A transmit enable written as 1 becomes active (`tx_on` rises) only at a rising edge of `fsync`, and only if the transmit queue is not empty at that edge. While the queue is empty the enable stays pending.
- R2: A receive enable written as 1 becomes active (`rx_on` rises) only at the next rising edge of `fsync`.
- R3: `sdo` is 1 whenever transmit is inactive, and also in every bit time after the 16th bit of a word until the next frame start.
- R4: At a frame start with transmit active and data queued, bit 15 of the oldest word appears on `sdo` after the frame-start edge. Bits 14 down to 0 follow, one per clock.
- R5: With receive active, `sdi` is sampled at the frame-start edge (bit 15) and at the 15 following edges (bits 14 to 0). After the 16th sample the word is the receive queue head (`rx_rdata`) and `rx_ready` is 1.
- R6: A write with `cfg_txrst`=1 takes effect at that edge. It forces `sdo` to 1, drops the word being shifted, empties the transmit queue, clears `tx_req` and `tx_on`, and clears the pending transmit enable, so a later frame start does not start transmit. It needs no second write.
- R7: A write with `cfg_rxrst`=1 takes effect at that edge. It empties the receive queue (`rx_ready`=0, `rx_req`=0), drops a partial word, clears `rx_on` and clears the pending receive enable.
- R8: `tx_req` is 1 exactly when transmit is active and the transmit queue holds no more than `tx_wm` words.
- R9: `rx_req` is 1 exactly when the receive queue holds at least one word and at least `rx_wm` words.
- R10: If transmit is active and the transmit queue is empty at a frame start, `sdo` stays 1 for that whole frame and `tx_on` stays 1.
- R11: Each queue holds 8 words. `tx_ready` is 0 when the transmit queue is full, and a push into a full queue is dropped. `tx_empty` is 1 when the transmit queue holds no word.
- R12: A transmit enable written as 0 leaves `tx_on` at 1 until the next rising edge of `fsync`. Queued words stay in the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame pulse; a rising edge starts a frame |
| sdi | input | 1 | Serial receive data |
| sdo | output | 1 | Serial transmit data; idles at 1 |
| cfg_wr | input | 1 | Control write strobe |
| cfg_txe | input | 1 | Transmit enable value to hold pending |
| cfg_rxe | input | 1 | Receive enable value to hold pending |
| cfg_txrst | input | 1 | Immediate transmit reset |
| cfg_rxrst | input | 1 | Immediate receive reset |
| tx_wm | input | 4 | Transmit request threshold (words) |
| rx_wm | input | 4 | Receive request threshold (words) |
| tx_push | input | 1 | Append `tx_wdata` to the transmit queue |
| tx_wdata | input | 16 | Word to transmit |
| rx_pop | input | 1 | Remove the receive queue head |
| rx_rdata | output | 16 | Receive queue head |
| tx_empty | output | 1 | Transmit queue empty |
| tx_ready | output | 1 | Transmit queue has space |
| rx_ready | output | 1 | Receive queue holds a word |
| rx_full | output | 1 | Receive queue full |
| tx_req | output | 1 | Transmit refill request |
| rx_req | output | 1 | Receive drain request |
| tx_on | output | 1 | Transmit enable in effect |
| rx_on | output | 1 | Receive enable in effect |

## Verification
The bench drives each input 1 ns after a rising clock edge and reads outputs 1 ns after the next one. Every result is therefore read exactly one edge after the stimulus that caused it. The frame-start edge puts bit 15 on `sdo` and sets the enable flags. Each of the 15 edges after it moves out the next bit, and the 15th of those makes the received word visible at the queue head. Queue flags and requests follow a push, a pop or a reset write by one edge. The deferral checks read the enable flags in the cycles between a write and the frame pulse, and again after the pulse.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
    localparam int unsigned SSP_WORD_W = 16;
    localparam int unsigned SSP_DEPTH  = 8;
endpackage

// File: rtl/ssp_fifo.sv
`timescale 1ns/1ps
module ssp_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic do_push, do_pop;

    assign full    = (q.cnt == CW'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign count   = q.cnt;
    assign head    = q.mem[q.rp];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        d = q;
        if (clr) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
        end else begin
            if (do_push) begin
                d.mem[q.wp] = wdata;
                d.wp        = q.wp + AW'(1);
            end
            if (do_pop) begin
                d.rp = q.rp + AW'(1);
            end
            d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/ssp_tx.sv
`timescale 1ns/1ps
module ssp_tx #(
    parameter int unsigned W = 16,
    localparam int unsigned CNTW = $clog2(W) + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         fs_rise,
    input  logic         cfg_wr,
    input  logic         cfg_en,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_head,
    output logic         fifo_pop,
    output logic         sdo,
    output logic         active
);
    typedef struct packed {
        logic            pend;
        logic            act;
        logic [W-1:0]    sh;
        logic [CNTW-1:0] left;
        logic            line;
    } tx_st_t;

    tx_st_t q, d;

    assign sdo    = q.line;
    assign active = q.act;

    always_comb begin
        d        = q;
        fifo_pop = 1'b0;
        if (clr) begin
            d      = '0;
            d.line = 1'b1;
        end else begin
            if (cfg_wr) d.pend = cfg_en;
            if (fs_rise) begin
                // enable decision uses the value pending before this edge
                d.act = q.pend & (q.act | ~fifo_empty);
                if (d.act && !fifo_empty) begin
                    fifo_pop = 1'b1;
                    d.line   = fifo_head[W-1];
                    d.sh     = {fifo_head[W-2:0], 1'b0};
                    d.left   = CNTW'(W - 1);
                end else begin
                    d.line = 1'b1;
                    d.sh   = '0;
                    d.left = '0;
                end
            end else if (q.left != '0) begin
                d.line = q.sh[W-1];
                d.sh   = {q.sh[W-2:0], 1'b0};
                d.left = q.left - CNTW'(1);
            end else begin
                d.line = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.line <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/ssp_rx.sv
`timescale 1ns/1ps
module ssp_rx #(
    parameter int unsigned W = 16,
    localparam int unsigned CNTW = $clog2(W) + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         fs_rise,
    input  logic         cfg_wr,
    input  logic         cfg_en,
    input  logic         sdi,
    output logic         push,
    output logic [W-1:0] word,
    output logic         active
);
    typedef struct packed {
        logic            pend;
        logic            act;
        logic [W-2:0]    sh;
        logic [CNTW-1:0] got;
    } rx_st_t;

    rx_st_t q, d;

    assign active = q.act;

    always_comb begin
        d    = q;
        push = 1'b0;
        word = {q.sh, sdi};
        if (clr) begin
            d = '0;
        end else begin
            if (cfg_wr) d.pend = cfg_en;
            if (fs_rise) begin
                d.act = q.pend;
                if (q.pend) begin
                    d.sh  = {{(W-2){1'b0}}, sdi};
                    d.got = CNTW'(1);
                end else begin
                    d.sh  = '0;
                    d.got = '0;
                end
            end else if (q.act && q.got != '0) begin
                if (q.got == CNTW'(W - 1)) begin
                    push  = 1'b1;
                    d.sh  = '0;
                    d.got = '0;
                end else begin
                    d.sh  = {q.sh[W-3:0], sdi};
                    d.got = q.got + CNTW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/ssp_frame_port.sv
`timescale 1ns/1ps
module ssp_frame_port
    import ssp_pkg::*;
#(
    parameter int unsigned W     = SSP_WORD_W,
    parameter int unsigned DEPTH = SSP_DEPTH,
    localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fsync,
    input  logic          sdi,
    output logic          sdo,
    input  logic          cfg_wr,
    input  logic          cfg_txe,
    input  logic          cfg_rxe,
    input  logic          cfg_txrst,
    input  logic          cfg_rxrst,
    input  logic [CW-1:0] tx_wm,
    input  logic [CW-1:0] rx_wm,
    input  logic          tx_push,
    input  logic [W-1:0]  tx_wdata,
    input  logic          rx_pop,
    output logic [W-1:0]  rx_rdata,
    output logic          tx_empty,
    output logic          tx_ready,
    output logic          rx_ready,
    output logic          rx_full,
    output logic          tx_req,
    output logic          rx_req,
    output logic          tx_on,
    output logic          rx_on
);
    typedef struct packed {
        logic fs;
    } top_st_t;

    top_st_t q, d;
    logic          fs_rise, tx_clr, rx_clr;
    logic          txf_pop, txf_full, txf_empty;
    logic [W-1:0]  txf_head;
    logic [CW-1:0] txf_cnt;
    logic          rxf_push, rxf_full, rxf_empty;
    logic [W-1:0]  rxf_word;
    logic [CW-1:0] rxf_cnt;

    always_comb begin
        d    = q;
        d.fs = fsync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fs_rise = fsync & ~q.fs;
    assign tx_clr  = cfg_wr & cfg_txrst;
    assign rx_clr  = cfg_wr & cfg_rxrst;

    ssp_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr),
        .push(tx_push), .wdata(tx_wdata), .pop(txf_pop),
        .head(txf_head), .count(txf_cnt), .full(txf_full), .empty(txf_empty)
    );

    ssp_tx #(.W(W)) u_tx (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .fs_rise(fs_rise),
        .cfg_wr(cfg_wr), .cfg_en(cfg_txe),
        .fifo_empty(txf_empty), .fifo_head(txf_head), .fifo_pop(txf_pop),
        .sdo(sdo), .active(tx_on)
    );

    ssp_rx #(.W(W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .fs_rise(fs_rise),
        .cfg_wr(cfg_wr), .cfg_en(cfg_rxe), .sdi(sdi),
        .push(rxf_push), .word(rxf_word), .active(rx_on)
    );

    ssp_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr),
        .push(rxf_push), .wdata(rxf_word), .pop(rx_pop),
        .head(rx_rdata), .count(rxf_cnt), .full(rxf_full), .empty(rxf_empty)
    );

    assign tx_empty = txf_empty;
    assign tx_ready = ~txf_full;
    assign rx_ready = ~rxf_empty;
    assign rx_full  = rxf_full;
    assign tx_req   = tx_on && (txf_cnt <= tx_wm);
    assign rx_req   = !rxf_empty && (rxf_cnt >= rx_wm);
endmodule

// File: rtl/ssp_frame_port_chk.sv
`timescale 1ns/1ps
module ssp_frame_port_chk (
    input logic clk,
    input logic rst_n,
    input logic fsync,
    input logic sdo,
    input logic cfg_wr,
    input logic cfg_txrst,
    input logic cfg_rxrst,
    input logic tx_empty,
    input logic tx_ready,
    input logic rx_ready,
    input logic tx_req,
    input logic rx_req,
    input logic tx_on,
    input logic rx_on
);
    logic fs_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_prev <= 1'b0;
        else        fs_prev <= fsync;
    end

    a_r1_tx_starts_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_on) |-> $past(fsync && !fs_prev && !tx_empty));

    a_r2_rx_starts_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_on) |-> $past(fsync && !fs_prev));

    a_r3_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_on |-> sdo);

    a_r6_tx_reset_now: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_txrst) |=> (sdo && !tx_on && tx_empty && !tx_req));

    a_r7_rx_reset_now: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_rxrst) |=> (!rx_on && !rx_ready && !rx_req));

    a_r8_req_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> tx_on);

    a_r11_empty_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_ready);

    a_r12_tx_stops_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_on) |-> ($past(fsync && !fs_prev) || $past(cfg_wr && cfg_txrst)));
endmodule

bind ssp_frame_port ssp_frame_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .sdo(sdo),
    .cfg_wr(cfg_wr), .cfg_txrst(cfg_txrst), .cfg_rxrst(cfg_rxrst),
    .tx_empty(tx_empty), .tx_ready(tx_ready), .rx_ready(rx_ready),
    .tx_req(tx_req), .rx_req(rx_req), .tx_on(tx_on), .rx_on(rx_on)
);

// File: tb/sim_ssp_frame_port.sv
`timescale 1ns/1ps
module sim_ssp_frame_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fsync = 1'b0, sdi = 1'b0, sdo;
    logic        cfg_wr = 1'b0, cfg_txe = 1'b0, cfg_rxe = 1'b0;
    logic        cfg_txrst = 1'b0, cfg_rxrst = 1'b0;
    logic [3:0]  tx_wm = 4'd2, rx_wm = 4'd2;
    logic        tx_push = 1'b0, rx_pop = 1'b0;
    logic [15:0] tx_wdata = '0, rx_rdata;
    logic        tx_empty, tx_ready, rx_ready, rx_full;
    logic        tx_req, rx_req, tx_on, rx_on;

    int nvec = 0;
    int nfail = 0;
    int cyc = 0;
    bit done = 1'b0;

    localparam logic [31:0] VEC [6] = '{
        32'hA5C3_3C5A, 32'h8001_7FFE, 32'hFFFF_0000,
        32'h0000_FFFF, 32'h1234_EDCB, 32'h6B19_94E6
    };

    always #2.5 clk = ~clk;

    ssp_frame_port u0 (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .sdi(sdi), .sdo(sdo),
        .cfg_wr(cfg_wr), .cfg_txe(cfg_txe), .cfg_rxe(cfg_rxe),
        .cfg_txrst(cfg_txrst), .cfg_rxrst(cfg_rxrst),
        .tx_wm(tx_wm), .rx_wm(rx_wm), .tx_push(tx_push), .tx_wdata(tx_wdata),
        .rx_pop(rx_pop), .rx_rdata(rx_rdata), .tx_empty(tx_empty),
        .tx_ready(tx_ready), .rx_ready(rx_ready), .rx_full(rx_full),
        .tx_req(tx_req), .rx_req(rx_req), .tx_on(tx_on), .rx_on(rx_on)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic txe, input logic rxe, input logic txr, input logic rxr);
        cfg_txe = txe; cfg_rxe = rxe; cfg_txrst = txr; cfg_rxrst = rxr;
        cfg_wr = 1'b1;
        tick;
        cfg_wr = 1'b0; cfg_txrst = 1'b0; cfg_rxrst = 1'b0;
    endtask

    task automatic push(input logic [15:0] w);
        tx_wdata = w; tx_push = 1'b1;
        tick;
        tx_push = 1'b0;
    endtask

    task automatic pop;
        rx_pop = 1'b1;
        tick;
        rx_pop = 1'b0;
    endtask

    // frame of 16 bit times; optionally checks each transmitted bit
    task automatic frame(input logic [15:0] txw, input logic [15:0] rxw,
                         input bit ck, input string tag);
        sdi = rxw[15]; fsync = 1'b1;
        tick;
        fsync = 1'b0;
        if (ck) chk(tag, {31'd0, sdo}, {31'd0, txw[15]});
        for (int k = 14; k >= 0; k--) begin
            sdi = rxw[k];
            tick;
            if (ck) chk(tag, {31'd0, sdo}, {31'd0, txw[k]});
        end
        sdi = 1'b0;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                nvec++; nfail++;
                $display("FAIL watchdog actual=%0d expected<100000", cyc);
                finish_run();
            end
        end
    end

    initial begin : main
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        // reset state
        chk("R3 reset sdo", {31'd0, sdo}, 32'd1);
        chk("R11 reset tx_empty", {31'd0, tx_empty}, 32'd1);
        chk("R11 reset tx_ready", {31'd0, tx_ready}, 32'd1);
        chk("R5 reset rx_ready", {31'd0, rx_ready}, 32'd0);
        chk("R8 reset tx_req", {31'd0, tx_req}, 32'd0);
        chk("R9 reset rx_req", {31'd0, rx_req}, 32'd0);
        chk("R1 reset tx_on", {31'd0, tx_on}, 32'd0);
        chk("R2 reset rx_on", {31'd0, rx_on}, 32'd0);

        // R1: enable with empty queue stays pending
        cfg(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R1 no frame yet", {31'd0, tx_on}, 32'd0);
        frame(16'hFFFF, 16'h0000, 1'b1, "R3 line idle");
        chk("R1 empty queue keeps pending", {31'd0, tx_on}, 32'd0);
        chk("R2 rx not enabled", {31'd0, rx_on}, 32'd0);

        // vector table: serial out and in
        cfg(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R2 deferred before frame", {31'd0, rx_on}, 32'd0);
        for (int i = 0; i < 6; i++) begin
            push(VEC[i][31:16]);
            if (i == 0) chk("R1 deferred with data", {31'd0, tx_on}, 32'd0);
            frame(VEC[i][31:16], VEC[i][15:0], 1'b1, "R4 tx bit");
            if (i == 0) begin
                chk("R1 active after frame", {31'd0, tx_on}, 32'd1);
                chk("R2 active after frame", {31'd0, rx_on}, 32'd1);
            end
            chk("R5 rx_ready", {31'd0, rx_ready}, 32'd1);
            chk("R5 rx word", {16'd0, rx_rdata}, {16'd0, VEC[i][15:0]});
            tick;
            chk("R3 high after word", {31'd0, sdo}, 32'd1);
            pop;
        end

        // R8 / R9 thresholds (tx_wm = rx_wm = 2)
        chk("R8 empty queue requests", {31'd0, tx_req}, 32'd1);
        push(16'hC001);
        push(16'hC002);
        chk("R8 count equals mark", {31'd0, tx_req}, 32'd1);
        push(16'hC003);
        chk("R8 count above mark", {31'd0, tx_req}, 32'd0);
        frame(16'hC001, 16'h0F0F, 1'b1, "R4 tx bit");
        chk("R9 one word below mark", {31'd0, rx_req}, 32'd0);
        frame(16'hC002, 16'hF0F0, 1'b1, "R4 tx bit");
        chk("R9 two words at mark", {31'd0, rx_req}, 32'd1);
        chk("R8 one word left", {31'd0, tx_req}, 32'd1);
        frame(16'hC003, 16'h0000, 1'b1, "R4 tx bit");

        // R10 underflow
        frame(16'hFFFF, 16'h0000, 1'b1, "R10 underflow line");
        chk("R10 stays active", {31'd0, tx_on}, 32'd1);

        // R11 depth
        for (int i = 0; i < 9; i++) begin
            push(16'h7100 + 16'(i));
            if (i >= 7) chk("R11 full no room", {31'd0, tx_ready}, 32'd0);
        end
        for (int i = 0; i < 8; i++) frame(16'h7100 + 16'(i), 16'h0000, 1'b1, "R11 stored word");
        chk("R11 drained", {31'd0, tx_empty}, 32'd1);
        frame(16'hFFFF, 16'h0000, 1'b1, "R11 ninth push dropped");

        // R12 disable deferred
        cfg(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R12 still active", {31'd0, tx_on}, 32'd1);
        push(16'h5A3C);
        frame(16'hFFFF, 16'h0000, 1'b1, "R12 no send");
        chk("R12 off after frame", {31'd0, tx_on}, 32'd0);
        chk("R12 word kept", {31'd0, tx_empty}, 32'd0);

        // R6 transmit reset mid-word
        push(16'h1111);
        cfg(1'b1, 1'b1, 1'b0, 1'b0);
        fsync = 1'b1;
        tick;
        fsync = 1'b0;
        chk("R6 sending before reset", {31'd0, tx_on}, 32'd1);
        repeat (3) tick;
        cfg(1'b1, 1'b1, 1'b1, 1'b0);
        chk("R6 sdo high", {31'd0, sdo}, 32'd1);
        chk("R6 tx_on clear", {31'd0, tx_on}, 32'd0);
        chk("R6 queue empty", {31'd0, tx_empty}, 32'd1);
        chk("R6 req clear", {31'd0, tx_req}, 32'd0);
        repeat (12) begin
            tick;
            chk("R6 line stays high", {31'd0, sdo}, 32'd1);
        end
        push(16'h0000);
        frame(16'hFFFF, 16'h0000, 1'b1, "R6 no restart");
        chk("R6 pending cleared", {31'd0, tx_on}, 32'd0);

        // R7 receive reset
        chk("R7 queue holds data", {31'd0, rx_ready}, 32'd1);
        cfg(1'b0, 1'b1, 1'b0, 1'b1);
        chk("R7 rx_ready clear", {31'd0, rx_ready}, 32'd0);
        chk("R7 rx_req clear", {31'd0, rx_req}, 32'd0);
        chk("R7 rx_on clear", {31'd0, rx_on}, 32'd0);
        frame(16'hFFFF, 16'hBEEF, 1'b0, "R7");
        chk("R7 pending cleared", {31'd0, rx_on}, 32'd0);
        chk("R7 nothing captured", {31'd0, rx_ready}, 32'd0);

        done = 1'b1;
        finish_run();
    end
endmodule